// File: doc/BRIEF.md
# DRAM Geometry-Probe Aliasing Memory

This block is a small word-wide store that sits over the first 1 GiB of the DRAM address window. Boot firmware sizes an unknown DRAM part by programming a trial geometry and checking where writes land. This block reproduces that behaviour for a fixed, known part. Each byte offset is cut into a column field in the low bits, a bank field directly above it and a row field above that, using the widths the firmware has programmed. Each field is then reduced to the position of its most significant set bit. Only bit positions below the real part's width for that field are considered. The resulting (row, bank, column) triple picks one of 16 x 3 x 13 storage words, so many offsets alias onto the same word, as they would on a real part with unconnected address lines.

The store switches itself on only when the programmed geometry differs from the real part's geometry. Otherwise it raises a pass-through indication and leaves all accesses to the real memory, which is outside this block. The real part is chosen at elaboration: 256, 512 or 1024 MiB. All three have 3 bank bits and 13 column bits, with 12, 13 or 14 row bits respectively. Any other size stops elaboration.

Top module: `geom_alias_mem`

## Requirements
- R1: After reset the overlay is off, `pass_through` is 1 and no read data is returned.
- R2: A pulse on `geom_load` captures the three programmed widths. From the next cycle, `overlay_on` is 1 if any of the row, bank or column width differs from the real part, and 0 if all three match. Without a load, `overlay_on` keeps its value.
- R3: The column field is the low `col` bits of `acc_addr`. The bank field is the next `bank` bits. The row field is the next `row` bits above those.
- R4: Each field's cell index is the position of its highest set bit among the positions below the real part's width for that field: 12/13/14 for row, 3 for bank, 13 for column. The index is 0 when no such bit is set.
- R5: While the overlay is on, a write stores `acc_wdata` in the selected cell. A read raises `rd_valid` one cycle later with that cell's contents on `rd_data`. A write never raises `rd_valid`.
- R6: Two offsets whose fields have the same highest-bit triple reach the same cell. A write through one offset is read back through the other.
- R7: While the overlay is off, accesses are ignored. No `rd_valid` is raised, and a write leaves the cell unchanged, as a later read with the overlay on shows.
- R8: An access in the same cycle as `geom_load` is decoded and gated with the geometry and overlay state that held before the load.
- R9: A cell never written since power-up reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| geom_load | input | 1 | Capture the programmed widths this cycle |
| geom_row_w | input | 5 | Programmed row width in bits |
| geom_bank_w | input | 2 | Programmed bank width in bits |
| geom_col_w | input | 5 | Programmed column width in bits |
| acc_valid | input | 1 | Access request this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 30 | Byte offset inside the 1 GiB window |
| acc_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data, valid with `rd_valid` |
| rd_valid | output | 1 | Read data returned (one cycle after a read) |
| overlay_on | output | 1 | Alias store is active |
| pass_through | output | 1 | Accesses belong to the real memory |

## Verification
A geometry load and an access can fall in the same cycle. The new widths must not change how that access is decoded or whether it is served. The bench provokes this by issuing a read in the cycle that reloads a matching geometry. Under the old widths, that read's offset selects a previously written cell; under the new widths, it would select an unwritten cell. The bench expects the old cell's data with `rd_valid` high, and expects the overlay to be off from the following cycle.

// File: rtl/geom_alias_mem.sv
module geom_alias_mem #(
  parameter int ACTUAL_MIB = 256,
  parameter int ADDR_W     = 30,
  parameter int DATA_W     = 32,
  parameter int ROW_SLOTS  = 16,
  parameter int BANK_SLOTS = 3,
  parameter int COL_SLOTS  = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              geom_load,
  input  logic [4:0]        geom_row_w,
  input  logic [1:0]        geom_bank_w,
  input  logic [4:0]        geom_col_w,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [DATA_W-1:0] acc_wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              overlay_on,
  output logic              pass_through
);

  localparam int ACT_ROW  = (ACTUAL_MIB == 256) ? 12 :
                            (ACTUAL_MIB == 512) ? 13 :
                            (ACTUAL_MIB == 1024) ? 14 : 0;
  localparam int ACT_BANK = 3;
  localparam int ACT_COL  = 13;
  localparam int CELLS    = ROW_SLOTS * BANK_SLOTS * COL_SLOTS;
  localparam int IDX_W    = $clog2(CELLS);

  generate
    if (ACT_ROW == 0) begin : g_bad_size
      $error("geom_alias_mem: unsupported ACTUAL_MIB");
    end
  endgenerate

  logic [4:0] cfg_row, cfg_col;
  logic [1:0] cfg_bank;
  logic       mismatch;

  assign mismatch = (geom_row_w != 5'(ACT_ROW)) ||
                    (geom_bank_w != 2'(ACT_BANK)) ||
                    (geom_col_w != 5'(ACT_COL));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_row    <= 5'(ACT_ROW);
      cfg_bank   <= 2'(ACT_BANK);
      cfg_col    <= 5'(ACT_COL);
      overlay_on <= 1'b0;
    end else if (geom_load) begin
      cfg_row    <= geom_row_w;
      cfg_bank   <= geom_bank_w;
      cfg_col    <= geom_col_w;
      overlay_on <= mismatch;
    end
  end

  assign pass_through = !overlay_on;

  function automatic logic [63:0] low_mask(input logic [5:0] w);
    low_mask = (64'd1 << w) - 64'd1;
  endfunction

  function automatic logic [3:0] top_bit(input logic [15:0] f, input int lim);
    top_bit = '0;
    for (int i = 0; i < 16; i++)
      if (i < lim && f[i]) top_bit = 4'(i);
  endfunction

  logic [63:0] addr64;
  logic [15:0] col_f, bank_f, row_f;
  logic [3:0]  col_i, bank_i, row_i;
  logic [IDX_W-1:0] cell_idx;

  assign addr64 = 64'(acc_addr);
  assign col_f  = 16'(addr64 & low_mask({1'b0, cfg_col}));
  assign bank_f = 16'((addr64 >> cfg_col) & low_mask({4'b0, cfg_bank}));
  assign row_f  = 16'((addr64 >> ({1'b0, cfg_col} + {4'b0, cfg_bank})) &
                      low_mask({1'b0, cfg_row}));
  assign col_i  = top_bit(col_f, ACT_COL);
  assign bank_i = top_bit(bank_f, ACT_BANK);
  assign row_i  = top_bit(row_f, ACT_ROW);
  assign cell_idx = IDX_W'(row_i * (BANK_SLOTS * COL_SLOTS) +
                           bank_i * COL_SLOTS + col_i);

  logic [DATA_W-1:0] cells [CELLS];

  initial begin
    for (int i = 0; i < CELLS; i++) cells[i] = '0;
  end

  always_ff @(posedge clk) begin
    if (acc_valid && acc_write && overlay_on) cells[cell_idx] <= acc_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= acc_valid && !acc_write && overlay_on;
      if (acc_valid && !acc_write && overlay_on) rd_data <= cells[cell_idx];
    end
  end

endmodule

// File: rtl/geom_alias_mem_chk.sv
module geom_alias_mem_chk #(
  parameter int ACTUAL_MIB = 256
) (
  input logic       clk,
  input logic       rst_n,
  input logic       geom_load,
  input logic [4:0] geom_row_w,
  input logic [1:0] geom_bank_w,
  input logic [4:0] geom_col_w,
  input logic       acc_valid,
  input logic       acc_write,
  input logic       rd_valid,
  input logic       overlay_on,
  input logic       pass_through
);
  localparam logic [4:0] REAL_ROW = (ACTUAL_MIB == 1024) ? 5'd14 :
                                    (ACTUAL_MIB == 512) ? 5'd13 : 5'd12;

  logic same_geom;
  assign same_geom = geom_row_w == REAL_ROW && geom_bank_w == 2'd3 && geom_col_w == 5'd13;

  AST_MATCH_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    geom_load && same_geom |=> !overlay_on && pass_through); // R2
  AST_MISMATCH_ON: assert property (@(posedge clk) disable iff (!rst_n)
    geom_load && !same_geom |=> overlay_on && !pass_through); // R2
  AST_OVERLAY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !geom_load |=> $stable(overlay_on)); // R2
  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && !acc_write && overlay_on |=> rd_valid); // R5
  AST_WRITE_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && acc_write |=> !rd_valid); // R5
  AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !overlay_on |=> !rd_valid); // R7
endmodule

bind geom_alias_mem geom_alias_mem_chk #(.ACTUAL_MIB(ACTUAL_MIB)) u_chk (
  .clk(clk), .rst_n(rst_n), .geom_load(geom_load), .geom_row_w(geom_row_w),
  .geom_bank_w(geom_bank_w), .geom_col_w(geom_col_w), .acc_valid(acc_valid),
  .acc_write(acc_write), .rd_valid(rd_valid), .overlay_on(overlay_on),
  .pass_through(pass_through)
);

// File: tb/geom_alias_mem_tb.sv
module geom_alias_mem_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        geom_load = 1'b0;
  logic [4:0]  geom_row_w = 5'd12;
  logic [1:0]  geom_bank_w = 2'd3;
  logic [4:0]  geom_col_w = 5'd13;
  logic        acc_valid = 1'b0;
  logic        acc_write = 1'b0;
  logic [29:0] acc_addr = '0;
  logic [31:0] acc_wdata = '0;
  logic [31:0] rd_data;
  logic        rd_valid, overlay_on, pass_through;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  geom_alias_mem u_dut (
    .clk(clk), .rst_n(rst_n), .geom_load(geom_load), .geom_row_w(geom_row_w),
    .geom_bank_w(geom_bank_w), .geom_col_w(geom_col_w), .acc_valid(acc_valid),
    .acc_write(acc_write), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
    .rd_data(rd_data), .rd_valid(rd_valid), .overlay_on(overlay_on),
    .pass_through(pass_through)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic load(input logic [4:0] r, input logic [1:0] b, input logic [4:0] c);
    @(negedge clk);
    geom_load = 1'b1; geom_row_w = r; geom_bank_w = b; geom_col_w = c;
    @(negedge clk);
    geom_load = 1'b0;
  endtask

  task automatic wr(input logic [29:0] a, input logic [31:0] d);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = 1'b1; acc_addr = a; acc_wdata = d;
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b0;
  endtask

  task automatic rd(input logic [29:0] a, output logic v, output logic [31:0] d);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = 1'b0; acc_addr = a;
    @(negedge clk);
    acc_valid = 1'b0;
    v = rd_valid; d = rd_data;
  endtask

  // {write, addr[29:0], wdata, expected}; geometry row 13, bank 3, col 13
  localparam logic [94:0] VECS [11] = '{
    {1'b1, 30'h0000_0000, 32'hA1A1_0001, 32'h0},
    {1'b1, 30'h0000_1000, 32'hB2B2_0002, 32'h0},
    {1'b1, 30'h0000_4000, 32'hC3C3_0003, 32'h0},
    {1'b1, 30'h0800_0000, 32'hD4D4_0004, 32'h0},
    {1'b1, 30'h1000_0000, 32'hE5E5_0005, 32'h0},
    {1'b0, 30'h0000_0001, 32'h0, 32'hE5E5_0005},
    {1'b0, 30'h0000_1FFF, 32'h0, 32'hB2B2_0002},
    {1'b0, 30'h0000_6000, 32'h0, 32'hC3C3_0003},
    {1'b0, 30'h0FFF_0000, 32'h0, 32'hD4D4_0004},
    {1'b0, 30'h0000_8000, 32'h0, 32'h0},
    {1'b0, 30'h0000_2000, 32'h0, 32'hE5E5_0005}
  };

  initial begin
    logic v;
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 overlay_on", 32'(overlay_on), 32'd0);
    check("R1 pass_through", 32'(pass_through), 32'd1);
    check("R1 rd_valid", 32'(rd_valid), 32'd0);

    load(5'd13, 2'd3, 5'd13);
    check("R2 row mismatch turns overlay on", 32'(overlay_on), 32'd1);
    check("R2 pass_through low", 32'(pass_through), 32'd0);

    // R4 R5 R6 R9 table walk
    for (int i = 0; i < 11; i++) begin
      if (VECS[i][94]) begin
        wr(VECS[i][93:64], VECS[i][63:32]);
        check("R5 write gives no rd_valid", 32'(rd_valid), 32'd0);
      end else begin
        rd(VECS[i][93:64], v, d);
        check("R5 rd_valid", 32'(v), 32'd1);
        check("R4 R6 R9 read data", d, VECS[i][31:0]);
      end
    end

    // R3: narrower column and bank fields move the field boundaries
    load(5'd12, 2'd2, 5'd10);
    check("R2 col/bank mismatch keeps overlay on", 32'(overlay_on), 32'd1);
    rd(30'h0000_0800, v, d);
    check("R3 bank field above col 10", d, 32'hC3C3_0003);
    rd(30'h0000_1000, v, d);
    check("R3 row field above bank", d, 32'hE5E5_0005);
    rd(30'h0000_0200, v, d);
    check("R3 R9 col bit 9 unwritten", d, 32'h0);

    // R8: read during a load of the matching geometry uses the old state
    @(negedge clk);
    geom_load = 1'b1; geom_row_w = 5'd12; geom_bank_w = 2'd3; geom_col_w = 5'd13;
    acc_valid = 1'b1; acc_write = 1'b0; acc_addr = 30'h0000_0800;
    @(negedge clk);
    geom_load = 1'b0; acc_valid = 1'b0;
    check("R8 read served under old state", 32'(rd_valid), 32'd1);
    check("R8 data from old geometry", rd_data, 32'hC3C3_0003);
    check("R2 matching geometry turns overlay off", 32'(overlay_on), 32'd0);
    check("R2 pass_through high", 32'(pass_through), 32'd1);

    // R7: accesses ignored while off
    wr(30'h0000_1000, 32'hFFFF_FFFF);
    rd(30'h0000_1000, v, d);
    check("R7 no rd_valid while off", 32'(v), 32'd0);
    repeat (2) @(negedge clk);
    check("R2 overlay holds without load", 32'(overlay_on), 32'd0);
    load(5'd13, 2'd3, 5'd13);
    rd(30'h0000_1000, v, d);
    check("R7 write while off left cell intact", d, 32'hB2B2_0002);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule